// File: doc/BRIEF.md
# Configuration Bitstream Loader Sequencer

This block is a bus master that programs one of three configurable target devices through a small 16-bit register window. That window holds a control register, a status register, a data register and a mask register. A load arms the chosen target with a two-step control handshake. It then waits for the target to confirm, pulls configuration bytes from a byte stream, and writes them as 16-bit words. After every word it waits for the target to signal readiness again. Every wait is bounded, and the block reports which wait gave up.

A load with a byte count of zero performs only the arming handshake, so it acts as a reset of that target. A separate full-reset command clears the control register and resets the three targets in ascending order. It then clears the mask register. Register accesses leave the block as single request/acknowledge transactions, and the request is held until it is acknowledged. Only one command runs at a time, and the block reports busy, done and an error code.

Top module: `cfgld_loader`

## Requirements
- R1: A start pulse is accepted only while the block is idle. A start pulse seen while busy has no effect on the command in progress or on its register traffic.
- R2: A load of target t (0 to 2) first writes the control register (select 0) with 0x0080|t and then with 0x00C0|t. It then reads the status register (select 1) until status bit 1 is set.
- R3: After the first wait, the control register is written with 0x0080|t again. Status is then read until it equals exactly 0x0003, and a status of 0x0002 does not end this wait.
- R4: The byte count L gives floor(L/2) data words, each written to the data register (select 2). The first byte of each pair sits in bits 7:0 and the second in bits 15:8. An odd final byte is neither taken from the stream nor written.
- R5: After each data word, status is read until bit 1 is set. No further byte is taken from the stream before that.
- R6: Each wait gives up after POLL_LIMIT status reads that fail, and exactly POLL_LIMIT reads are made. The error code is 1 for the first wait, 2 for the exact-match wait and 3 for a per-word wait. No register write follows a failure.
- R7: A successful load ends with a write of 0 to the control register, followed by a done pulse with error low and error code 0.
- R8: A load with a byte count of 0 or 1 performs only the two waits and the final control clear, and takes no bytes.
- R9: A full reset writes 0 to control. It then performs the arming handshake followed by a control clear for targets 0, 1 and 2 in that order. Finally it writes 0 to the mask register (select 3).
- R10: After reset the block is idle: busy, done, bus_req, byte_ready and error are low and the error code is 0.
- R11: While a bus request is not acknowledged, the request, direction, select and write data hold their values.
- R12: done is high for exactly one cycle, and busy is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start pulse |
| full_reset | input | 1 | Selects full reset instead of a single load |
| target | input | 2 | Target index for a load |
| byte_len | input | LEN_W | Number of bitstream bytes for a load |
| byte_valid | input | 1 | Stream byte available |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Block takes the stream byte |
| bus_req | output | 1 | Register transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 2 | Register select: 0 control, 1 status, 2 data, 3 mask |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_rdata | input | 16 | Read data, valid with acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last command failed |
| err_code | output | 2 | Failed wait: 0 none, 1 arm, 2 confirm, 3 word |

## Verification
The bench holds the exact-match wait at status 0x0002. A design that tested only bit 1 there would move on early and write data that the bench does not expect. It also runs an odd byte count, where a design that packed the trailing byte would issue an extra data write or take one byte too many. A wait that is satisfied on the last allowed read must succeed, while one that never completes must fail after exactly the limit. An off-by-one counter would either abort the boundary case or make one read too many or too few. Slow acknowledges and a start pulse injected mid-run catch a request that changes before it is acknowledged and a start pulse that is taken while busy.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int NUM_TARGETS = 3;
    localparam int TGT_W       = $clog2(NUM_TARGETS);
    localparam int REG_W       = 16;
    localparam int BYTE_W      = 8;
    localparam int LANES       = REG_W / BYTE_W;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ARM     = 2'd1,
        ERR_CONFIRM = 2'd2,
        ERR_WORD    = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_PRE,
        ST_ARM_LO,
        ST_ARM_HI,
        ST_POLL_ARM,
        ST_REARM,
        ST_POLL_CONF,
        ST_FETCH,
        ST_DATA,
        ST_POLL_WORD,
        ST_FINISH,
        ST_MASK,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic             req;
        logic             we;
        reg_sel_e         sel;
        logic [REG_W-1:0] wdata;
    } bus_op_t;

    localparam logic [REG_W-1:0] CTRL_ENABLE    = 16'h0080;
    localparam logic [REG_W-1:0] CTRL_ARM       = 16'h0040;
    localparam logic [REG_W-1:0] STAT_CONFIRMED = 16'h0003;
    localparam int               STAT_RDY_BIT   = 1;

    function automatic logic [REG_W-1:0] ctrl_word(input logic [TGT_W-1:0] t, input logic arm);
        return CTRL_ENABLE | (arm ? CTRL_ARM : '0) | REG_W'(t);
    endfunction

    function automatic bus_op_t wr_op(input reg_sel_e s, input logic [REG_W-1:0] d);
        return '{req: 1'b1, we: 1'b1, sel: s, wdata: d};
    endfunction

    function automatic bus_op_t rd_op(input reg_sel_e s);
        return '{req: 1'b1, we: 1'b0, sel: s, wdata: '0};
    endfunction

    function automatic logic is_poll(input state_e s);
        return (s == ST_POLL_ARM) || (s == ST_POLL_CONF) || (s == ST_POLL_WORD);
    endfunction

endpackage

// File: rtl/cfgld_poll_ctr.sv
module cfgld_poll_ctr #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (miss && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LIMIT))
        else $error("poll counter beyond limit");

endmodule

// File: rtl/cfgld_packer.sv
module cfgld_packer
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              want,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              word_valid,
    output logic [REG_W-1:0]  word
);
    localparam int FW = $clog2(LANES + 1);

    logic [FW-1:0] fill_q;

    assign word_valid = (fill_q == FW'(LANES));
    assign in_ready   = want && !word_valid;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill_q <= '0;
        end else if (in_valid && in_ready) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (in_valid && in_ready && fill_q == FW'(k)) begin
                lane_q <= in_data;
            end
        end
        assign word[k*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
    import cfgld_pkg::*;
#(
    parameter int POLL_LIMIT = 1000,
    parameter int LEN_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              full_reset,
    input  logic [TGT_W-1:0]  target,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_sel,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [REG_W-1:0]  bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code
);
    state_e             state_q;
    logic [TGT_W-1:0]   tgt_q;
    logic               full_q;
    logic [LEN_W-1:0]   words_q;
    err_e               err_q;

    bus_op_t            op;
    logic               stat_ok;
    logic               poll_last;
    logic               poll_miss;
    logic               word_valid;
    logic [REG_W-1:0]   word;
    logic               pk_clr;

    // register transaction chosen by the current state
    always_comb begin
        op = '{req: 1'b0, we: 1'b0, sel: SEL_CTRL, wdata: '0};
        unique case (state_q)
            ST_CLR_PRE, ST_FINISH: op = wr_op(SEL_CTRL, '0);
            ST_ARM_LO, ST_REARM:   op = wr_op(SEL_CTRL, ctrl_word(tgt_q, 1'b0));
            ST_ARM_HI:             op = wr_op(SEL_CTRL, ctrl_word(tgt_q, 1'b1));
            ST_POLL_ARM, ST_POLL_CONF, ST_POLL_WORD: op = rd_op(SEL_STAT);
            ST_DATA:               op = wr_op(SEL_DATA, word);
            ST_MASK:               op = wr_op(SEL_MASK, '0);
            default: ;
        endcase
    end

    assign bus_req   = op.req;
    assign bus_we    = op.we;
    assign bus_sel   = op.sel;
    assign bus_wdata = op.wdata;

    always_comb begin
        unique case (state_q)
            ST_POLL_CONF: stat_ok = (bus_rdata == STAT_CONFIRMED);
            default:      stat_ok = bus_rdata[STAT_RDY_BIT];
        endcase
    end

    assign poll_miss = is_poll(state_q) && bus_ack && !stat_ok;
    assign pk_clr    = (state_q == ST_IDLE) || (state_q == ST_DATA && bus_ack);

    cfgld_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk  (clk),
        .rst  (rst),
        .clr  (!is_poll(state_q)),
        .miss (poll_miss),
        .last (poll_last)
    );

    cfgld_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .want       (state_q == ST_FETCH),
        .clr        (pk_clr),
        .in_valid   (byte_valid),
        .in_data    (byte_data),
        .in_ready   (byte_ready),
        .word_valid (word_valid),
        .word       (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            full_q  <= 1'b0;
            words_q <= '0;
            err_q   <= ERR_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    full_q <= full_reset;
                    err_q  <= ERR_NONE;
                    if (full_reset) begin
                        tgt_q   <= '0;
                        words_q <= '0;
                        state_q <= ST_CLR_PRE;
                    end else begin
                        tgt_q   <= target;
                        words_q <= byte_len >> 1;
                        state_q <= ST_ARM_LO;
                    end
                end
                ST_CLR_PRE: if (bus_ack) state_q <= ST_ARM_LO;
                ST_ARM_LO:  if (bus_ack) state_q <= ST_ARM_HI;
                ST_ARM_HI:  if (bus_ack) state_q <= ST_POLL_ARM;
                ST_POLL_ARM: if (bus_ack) begin
                    if (stat_ok) begin
                        state_q <= ST_REARM;
                    end else if (poll_last) begin
                        err_q   <= ERR_ARM;
                        state_q <= ST_DONE;
                    end
                end
                ST_REARM: if (bus_ack) state_q <= ST_POLL_CONF;
                ST_POLL_CONF: if (bus_ack) begin
                    if (stat_ok) begin
                        state_q <= (words_q != '0) ? ST_FETCH : ST_FINISH;
                    end else if (poll_last) begin
                        err_q   <= ERR_CONFIRM;
                        state_q <= ST_DONE;
                    end
                end
                ST_FETCH: if (word_valid) state_q <= ST_DATA;
                ST_DATA: if (bus_ack) begin
                    words_q <= words_q - 1'b1;
                    state_q <= ST_POLL_WORD;
                end
                ST_POLL_WORD: if (bus_ack) begin
                    if (stat_ok) begin
                        state_q <= (words_q != '0) ? ST_FETCH : ST_FINISH;
                    end else if (poll_last) begin
                        err_q   <= ERR_WORD;
                        state_q <= ST_DONE;
                    end
                end
                ST_FINISH: if (bus_ack) begin
                    if (!full_q) begin
                        state_q <= ST_DONE;
                    end else if (tgt_q == TGT_W'(NUM_TARGETS - 1)) begin
                        state_q <= ST_MASK;
                    end else begin
                        tgt_q   <= tgt_q + 1'b1;
                        state_q <= ST_ARM_LO;
                    end
                end
                ST_MASK: if (bus_ack) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign error    = (err_q != ERR_NONE);
    assign err_code = err_q;

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_sel) && $stable(bus_wdata))
        else $error("bus request changed before acknowledge");

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(full_q))
        else $error("start taken while busy");

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy)
        else $error("done longer than one cycle");

    // R5
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> !bus_req)
        else $error("byte fetch overlaps a bus transaction");

    // R6
    err_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done)
        else $error("error raised outside completion");

endmodule

// File: tb/tb_cfgld_loader.sv
module tb_cfgld_loader;
    import cfgld_pkg::*;

    localparam int LIMIT = 1000;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic        full;
        logic [1:0]  tgt;
        logic [7:0]  len;
        logic [10:0] na;
        logic [10:0] nb;
        logic [10:0] nc;
        logic        slow;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'd6, 11'd0,    11'd0,    11'd0,    1'b0},
        '{1'b0, 2'd1, 8'd7, 11'd3,    11'd2,    11'd1,    1'b1},
        '{1'b0, 2'd2, 8'd0, 11'd5,    11'd4,    11'd0,    1'b0},
        '{1'b1, 2'd0, 8'd0, 11'd1,    11'd1,    11'd0,    1'b1},
        '{1'b0, 2'd2, 8'd4, 11'd2000, 11'd0,    11'd0,    1'b0},
        '{1'b0, 2'd0, 8'd4, 11'd0,    11'd2000, 11'd0,    1'b0},
        '{1'b0, 2'd1, 8'd4, 11'd0,    11'd0,    11'd2000, 1'b0},
        '{1'b0, 2'd1, 8'd2, 11'd999,  11'd999,  11'd999,  1'b0},
        '{1'b1, 2'd0, 8'd0, 11'd0,    11'd2000, 11'd0,    1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic full_reset = 1'b0;
    logic [1:0] target = '0;
    logic [LEN_W-1:0] byte_len = '0;
    logic byte_valid;
    logic [7:0] byte_data;
    logic byte_ready;
    logic bus_req, bus_we, bus_ack;
    logic [1:0] bus_sel;
    logic [15:0] bus_wdata, bus_rdata;
    logic busy, done, error;
    logic [1:0] err_code;

    always #5 clk = ~clk;

    cfgld_loader #(.POLL_LIMIT(LIMIT), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .start(start), .full_reset(full_reset),
        .target(target), .byte_len(byte_len),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // target and stream model
    logic [10:0] cur_na = '0, cur_nb = '0, cur_nc = '0;
    logic cur_slow = 1'b0;
    int cur_vi = 0;
    logic log_clr = 1'b0;
    logic ack_ph = 1'b1;
    logic [1:0] mdl_mode = '0;
    int mdl_cnt = 0;
    logic [17:0] wlog [64];
    int wlog_n = 0;
    int bidx = 0;
    int hold_viol = 0;
    logic pend_q = 1'b0;
    logic [18:0] pend_op = '0;

    function automatic logic [7:0] pat(input int k, input int vi);
        return 8'(k * 59 + vi * 17 + 5);
    endfunction

    assign bus_ack    = bus_req && ack_ph;
    assign byte_valid = ack_ph;
    assign byte_data  = pat(bidx, cur_vi);

    always_comb begin
        case (mdl_mode)
            2'd1:    bus_rdata = (mdl_cnt >= int'(cur_na)) ? 16'h0002 : 16'h0000;
            2'd2:    bus_rdata = (mdl_cnt >= int'(cur_nb)) ? 16'h0003 : 16'h0002;
            2'd3:    bus_rdata = (mdl_cnt >= int'(cur_nc)) ? 16'h0002 : 16'h0000;
            default: bus_rdata = 16'h0000;
        endcase
    end

    always @(posedge clk) begin
        ack_ph <= cur_slow ? ~ack_ph : 1'b1;
        pend_q  <= bus_req && !bus_ack;
        pend_op <= {bus_we, bus_sel, bus_wdata};
        if (pend_q && (!bus_req || {bus_we, bus_sel, bus_wdata} != pend_op))
            hold_viol <= hold_viol + 1;
        if (log_clr) begin
            wlog_n <= 0; bidx <= 0; mdl_mode <= 2'd0; mdl_cnt <= 0;
        end else begin
            if (byte_valid && byte_ready) bidx <= bidx + 1;
            if (bus_req && bus_ack) begin
                if (bus_we) begin
                    if (wlog_n < 64) wlog[wlog_n] <= {bus_sel, bus_wdata};
                    wlog_n <= wlog_n + 1;
                    mdl_cnt <= 0;
                    if (bus_sel == 2'd0) begin
                        if (bus_wdata[6]) mdl_mode <= 2'd1;
                        else if (bus_wdata[7] && mdl_mode == 2'd1) mdl_mode <= 2'd2;
                        else mdl_mode <= 2'd0;
                    end else if (bus_sel == 2'd2) begin
                        mdl_mode <= 2'd3;
                    end else begin
                        mdl_mode <= 2'd0;
                    end
                end else begin
                    mdl_cnt <= mdl_cnt + 1;
                end
            end
        end
    end

    // expected results
    logic [17:0] exp_w [64];
    int exp_n = 0;
    int exp_err = 0;
    int exp_bytes = 0;

    task automatic push(input logic [1:0] s, input logic [15:0] d);
        exp_w[exp_n] = {s, d};
        exp_n++;
    endtask

    task automatic arm_seq(input vec_t v, input logic [1:0] t, output bit ok);
        ok = 1'b0;
        push(2'd0, 16'h0080 | 16'(t));
        push(2'd0, 16'h00C0 | 16'(t));
        if (int'(v.na) >= LIMIT) begin exp_err = 1; return; end
        push(2'd0, 16'h0080 | 16'(t));
        if (int'(v.nb) >= LIMIT) begin exp_err = 2; return; end
        ok = 1'b1;
    endtask

    task automatic build(input vec_t v, input int vi);
        bit ok;
        exp_n = 0; exp_err = 0; exp_bytes = 0;
        if (v.full) begin
            push(2'd0, 16'h0000);
            for (int t = 0; t < 3; t++) begin
                arm_seq(v, 2'(t), ok);
                if (!ok) return;
                push(2'd0, 16'h0000);
            end
            push(2'd3, 16'h0000);
        end else begin
            arm_seq(v, v.tgt, ok);
            if (!ok) return;
            for (int w = 0; w < int'(v.len) / 2; w++) begin
                push(2'd2, {pat(2*w+1, vi), pat(2*w, vi)});
                exp_bytes += 2;
                if (int'(v.nc) >= LIMIT) begin exp_err = 3; return; end
            end
            push(2'd0, 16'h0000);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.full) return "R9";
        if (v.len < 2) return "R8";
        if (int'(v.na) >= LIMIT || int'(v.nb) >= LIMIT || int'(v.nc) >= LIMIT) return "R6";
        return "R2 R3 R4 R5 R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    task automatic run_vec(input vec_t v, input int vi, input bit inject);
        int bad;
        string tg;
        tg = tag_of(v);
        cur_na = v.na; cur_nb = v.nb; cur_nc = v.nc; cur_slow = v.slow; cur_vi = vi;
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        build(v, vi);
        start = 1'b1; full_reset = v.full; target = v.tgt; byte_len = LEN_W'(v.len);
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            start = 1'b1; full_reset = ~v.full; target = 2'd2; byte_len = 16'd20;
            @(negedge clk);
            start = 1'b0;
            tg = "R1";
        end
        while (!done) @(negedge clk);
        check(int'(err_code) == exp_err, tg, "error code", int'(err_code), exp_err);
        check(error == (exp_err != 0), tg, "error flag", int'(error), int'(exp_err != 0));
        @(negedge clk);
        check(!done && !busy, "R12", "done/busy after pulse", int'({done, busy}), 0);
        bad = 0;
        for (int i = 0; i < exp_n && i < wlog_n; i++)
            if (wlog[i] != exp_w[i]) bad++;
        check(wlog_n == exp_n, tg, "write count", wlog_n, exp_n);
        check(bad == 0, tg, "mismatched writes", bad, 0);
        check(bidx == exp_bytes, (v.len[0] ? "R4" : tg), "bytes taken", bidx, exp_bytes);
        if (exp_err != 0)
            check(mdl_cnt == LIMIT, "R6", "status reads in failed wait", mdl_cnt, LIMIT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(!busy && !done && !bus_req && !byte_ready, "R10", "idle outputs",
              int'({busy, done, bus_req, byte_ready}), 0);
        check(!error && err_code == 2'd0, "R10", "error after reset", int'({error, err_code}), 0);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i, 1'b0);
        // R1: start pulse during a run is ignored
        run_vec(VECS[0], 20, 1'b1);
        // R11: requests held through slow acknowledges
        check(hold_viol == 0, "R11", "request changes before ack", hold_viol, 0);
        report();
        $finish;
    end

endmodule